// File: doc/BRIEF.md
# Queued SPI Master

This block is a master-only SPI engine that works through a pre-loaded list of up to sixteen transfers with no processor attention between words. Each list slot holds a transmit word, a chip-select pattern and a hold flag. After the list is loaded, software picks a first and a last slot and pulses `start`. The engine then shifts each word out full duplex, writes the word it received back into that slot's receive location, and raises `done` together with a one-cycle `irq` once the last slot has finished.

Slots are written through a valid/ready load port. The port accepts a beat only while the engine is idle. `ld_ready` is low for the whole of a run, so an upstream writer must hold `ld_valid` and its data steady until it sees `ld_ready` high. A beat and a `start` pulse may arrive in the same cycle: the beat is accepted and the run sees its content. Received words are read back combinationally through `rd_addr`/`rd_data`.

The serial side uses clock mode 0, with SCK idling low. MOSI changes after a falling edge, MSB first, and MISO is captured on the rising edge. SCK runs at the system clock divided by 2·N, where N is the `div` input. The fastest rate is therefore half the system clock.

Top module: `queued_spi_master`

## Requirements
- R1: A load beat writes `ld_tx`, `ld_cs` and `ld_hold` into slot `ld_addr` when `ld_valid && ld_ready`. `ld_ready` is high exactly when `busy` is low.
- R2: A `start` pulse while idle runs slots from `start_ptr` to `end_ptr` inclusive, stepping up by one and wrapping from 15 to 0. A `start` while busy has no effect on the run.
- R3: SCK is low while idle and between words. Each word is sent MSB first, with MOSI stable at every rising SCK edge. MISO is captured on the rising edge, first bit into the MSB.
- R4: Within a word, successive rising SCK edges are 2·N system clocks apart, with N = `div` for 1..255 and N = 1 when `div` is 0. `div` must stay stable while busy.
- R5: During a word, `cs_n[i]` is low exactly for the bits `i` that are set in the slot's chip-select field. Chip select asserts N clocks before the first rising SCK edge and releases N clocks after the last falling edge.
- R6: When a slot's hold flag is 1 and it is not the last slot, chip select stays asserted into the next slot. Otherwise chip select releases for at least N clocks before the next slot asserts. The last slot always releases.
- R7: The word received during a slot is stored in that slot and appears on `rd_data` when `rd_addr` selects it.
- R8: `done` rises and `irq` pulses for exactly one cycle in the cycle that chip select releases after the last slot. An accepted `start` clears `done`.
- R9: `busy` goes high the cycle after an accepted `start` and falls in the same cycle that `done` rises.
- R10: A load beat accepted in the same cycle as `start` is used by that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Load beat valid |
| ld_ready | output | 1 | Load beat accepted (idle) |
| ld_addr | input | 4 | Slot to write |
| ld_tx | input | 8 | Transmit word |
| ld_cs | input | 4 | Chip-select pattern, bit i drives cs_n[i] |
| ld_hold | input | 1 | Keep chip select asserted into next slot |
| start | input | 1 | Launch pulse |
| start_ptr | input | 4 | First slot of the run |
| end_ptr | input | 4 | Last slot of the run |
| div | input | 8 | Half-period length N in system clocks |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished (sticky) |
| irq | output | 1 | One-cycle completion pulse |
| rd_addr | input | 4 | Receive slot to read |
| rd_data | output | 8 | Received word of that slot |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The two functions that can coincide are a load beat and the launch of a run. The bench drives both in one cycle in every run, rewriting the first slot's transmit word. The run is judged correct when the word captured on MOSI for that slot is the new one. A second `start` is issued one cycle into each run with a different first slot. That pulse is judged ignored when the count and order of words on the wire, and the single `irq`, still match the original range.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_LOW,
    ST_HIGH,
    ST_TRAIL,
    ST_GAP
  } qspi_state_e;
endpackage

// File: rtl/qspi_baud.sv
module qspi_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] eff;

  assign eff  = (div == '0) ? DIV_W'(1) : div;
  assign tick = en && (cnt == eff - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en || tick) cnt <= '0;
    else                 cnt <= cnt + DIV_W'(1);
  end

  // R4: the half-period counter never runs past its limit
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt < eff));
endmodule

// File: rtl/qspi_qram.sv
module qspi_qram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int NCS    = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              ld_we,
  input  logic [PTR_W-1:0]  ld_addr,
  input  logic [DATA_W-1:0] ld_tx,
  input  logic [NCS-1:0]    ld_cs,
  input  logic              ld_hold,
  input  logic [PTR_W-1:0]  q_addr,
  output logic [DATA_W-1:0] q_tx,
  output logic [NCS-1:0]    q_cs,
  output logic              q_hold,
  input  logic              rx_we,
  input  logic [DATA_W-1:0] rx_word,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] tx_mem [DEPTH];
  logic [NCS-1:0]    cs_mem [DEPTH];
  logic              hold_mem [DEPTH];
  logic [DATA_W-1:0] rx_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ld_we) begin
      tx_mem[ld_addr]   <= ld_tx;
      cs_mem[ld_addr]   <= ld_cs;
      hold_mem[ld_addr] <= ld_hold;
    end
    if (rx_we) rx_mem[q_addr] <= rx_word;
  end

  assign q_tx    = tx_mem[q_addr];
  assign q_cs    = cs_mem[q_addr];
  assign q_hold  = hold_mem[q_addr];
  assign rd_data = rx_mem[rd_addr];
endmodule

// File: rtl/queued_spi_master.sv
module queued_spi_master
  import qspi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int NCS    = 4,
  parameter int DIV_W  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [PTR_W-1:0]  ld_addr,
  input  logic [DATA_W-1:0] ld_tx,
  input  logic [NCS-1:0]    ld_cs,
  input  logic              ld_hold,
  input  logic              start,
  input  logic [PTR_W-1:0]  start_ptr,
  input  logic [PTR_W-1:0]  end_ptr,
  input  logic [DIV_W-1:0]  div,
  output logic              busy,
  output logic              done,
  output logic              irq,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NCS-1:0]    cs_n
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  qspi_state_e       state;
  logic [PTR_W-1:0]  ptr, end_q;
  logic [DATA_W-1:0] sh_tx, sh_rx;
  logic [BIT_W-1:0]  bitcnt;
  logic [NCS-1:0]    cs_q;
  logic              hold_q, cs_act, sck_q, done_q, irq_q;
  logic              tick, baud_en, rx_we;
  logic [DATA_W-1:0] q_tx;
  logic [NCS-1:0]    q_cs;
  logic              q_hold;

  assign busy     = (state != ST_IDLE);
  assign ld_ready = !busy;
  assign baud_en  = (state != ST_IDLE) && (state != ST_LOAD);
  assign rx_we    = (state == ST_TRAIL) && tick;

  qspi_baud #(.DIV_W(DIV_W)) baud_i (
    .clk(clk), .rst_n(rst_n), .en(baud_en), .div(div), .tick(tick)
  );

  qspi_qram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .NCS(NCS)) qram_i (
    .clk(clk),
    .ld_we(ld_valid && ld_ready), .ld_addr(ld_addr), .ld_tx(ld_tx),
    .ld_cs(ld_cs), .ld_hold(ld_hold),
    .q_addr(ptr), .q_tx(q_tx), .q_cs(q_cs), .q_hold(q_hold),
    .rx_we(rx_we), .rx_word(sh_rx),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ptr    <= '0;
      end_q  <= '0;
      sh_tx  <= '0;
      sh_rx  <= '0;
      bitcnt <= '0;
      cs_q   <= '0;
      hold_q <= 1'b0;
      cs_act <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          ptr    <= start_ptr;
          end_q  <= end_ptr;
          done_q <= 1'b0;
          state  <= ST_LOAD;
        end
        ST_LOAD: begin
          sh_tx  <= q_tx;
          cs_q   <= q_cs;
          hold_q <= q_hold;
          cs_act <= 1'b1;
          bitcnt <= '0;
          state  <= ST_LOW;
        end
        ST_LOW: if (tick) begin
          sh_rx <= {sh_rx[DATA_W-2:0], miso};
          sck_q <= 1'b1;
          state <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          sck_q <= 1'b0;
          if (bitcnt == LAST_BIT) begin
            state <= ST_TRAIL;
          end else begin
            bitcnt <= bitcnt + BIT_W'(1);
            sh_tx  <= {sh_tx[DATA_W-2:0], 1'b0};
            state  <= ST_LOW;
          end
        end
        ST_TRAIL: if (tick) begin
          if (ptr == end_q) begin
            cs_act <= 1'b0;
            done_q <= 1'b1;
            irq_q  <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            ptr <= (ptr == LAST_PTR) ? '0 : ptr + PTR_W'(1);
            if (hold_q) begin
              state <= ST_LOAD;
            end else begin
              cs_act <= 1'b0;
              state  <= ST_GAP;
            end
          end
        end
        ST_GAP: if (tick) state <= ST_LOAD;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sck  = sck_q;
  assign mosi = ((state == ST_LOW) || (state == ST_HIGH)) ? sh_tx[DATA_W-1] : 1'b0;
  assign cs_n = cs_act ? ~cs_q : '1;
  assign done = done_q;
  assign irq  = irq_q;

  // R3: serial clock rests low whenever no run is active
  a_r3_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
  // R4: SCK only changes on a half-period boundary
  a_r4_sck_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q != $past(sck_q)) |-> $past(tick));
  // R5: chip select is active while SCK is high
  a_r5_cs_during_clock: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |-> cs_act);
  // R6: finishing the last slot leaves chip select released
  a_r6_release_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (cs_n == '1));
  // R8: completion interrupt is a single-cycle pulse
  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R8: interrupt only with the done flag raised
  a_r8_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> done_q);
  // R9: busy ends exactly as done rises
  a_r9_busy_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(busy) && !busy));
endmodule

// File: tb/queued_spi_master_tb_top.sv
module queued_spi_master_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_valid = 1'b0;
  logic       ld_ready;
  logic [3:0] ld_addr = '0;
  logic [7:0] ld_tx = '0;
  logic [3:0] ld_cs = '0;
  logic       ld_hold = 1'b0;
  logic       start = 1'b0;
  logic [3:0] start_ptr = '0, end_ptr = '0;
  logic [7:0] div = 8'd1;
  logic       busy, done, irq;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       sck, mosi, miso;
  logic [3:0] cs_n;

  always #2 clk = ~clk;

  queued_spi_master dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_tx(ld_tx), .ld_cs(ld_cs), .ld_hold(ld_hold),
    .start(start), .start_ptr(start_ptr), .end_ptr(end_ptr), .div(div),
    .busy(busy), .done(done), .irq(irq), .rd_addr(rd_addr), .rd_data(rd_data),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int total = 0, bad = 0;
  logic [7:0] tb_tx [16];
  logic [3:0] tb_cs [16];
  logic       tb_hold [16];

  function automatic logic [7:0] resp(input int k);
    return 8'h3C ^ 8'(k * 29);
  endfunction

  // slave model and wire monitor, sampled on system clock edges
  logic mon_clr = 1'b0;
  int   exp_n = 1;
  int   cyc = 0, t_assert, t_release, t_fall, t_rise;
  int   xfer, bits, releases, irqs, lead_bad, per_bad, trail_bad, gap_bad;
  bit   prev_sck, prev_idle, lead_pend, saw_rel;
  logic [7:0] sh_cap;
  logic [7:0] cap_mosi [32];
  logic [3:0] cap_cs [32];

  assign miso = resp(xfer)[7 - bits];

  always @(posedge clk) begin
    cyc++;
    if (mon_clr) begin
      xfer = 0; bits = 0; releases = 0; irqs = 0;
      lead_bad = 0; per_bad = 0; trail_bad = 0; gap_bad = 0;
      prev_sck = 0; prev_idle = 1; lead_pend = 0; saw_rel = 0; sh_cap = '0;
    end else begin
      if (prev_idle && !(&cs_n)) begin
        t_assert = cyc; lead_pend = 1;
        if (saw_rel && (cyc - t_release) < exp_n) gap_bad++;
      end
      if (!prev_idle && (&cs_n)) begin
        releases++; t_release = cyc; saw_rel = 1;
        if (cyc - t_fall != exp_n) trail_bad++;
      end
      if (!prev_sck && sck) begin
        if (lead_pend) begin
          if (cyc - t_assert != exp_n) lead_bad++;
          lead_pend = 0;
        end
        if (bits != 0 && (cyc - t_rise) != 2 * exp_n) per_bad++;
        t_rise = cyc;
        if (bits == 0 && xfer < 32) cap_cs[xfer] = cs_n;
        sh_cap = {sh_cap[6:0], mosi};
        if (bits == 7) begin
          if (xfer < 32) cap_mosi[xfer] = sh_cap;
          xfer++; bits = 0;
        end else bits++;
      end
      if (prev_sck && !sck) t_fall = cyc;
      if (irq) irqs++;
      prev_sck = sck; prev_idle = &cs_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input int a, input logic [7:0] tx, input logic [3:0] cs, input bit h);
    @(negedge clk);
    ld_valid = 1; ld_addr = 4'(a); ld_tx = tx; ld_cs = cs; ld_hold = h;
    tb_tx[a] = tx; tb_cs[a] = cs; tb_hold[a] = h;
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic run(input int sp, input int ep, input int dv, input logic [7:0] newtx);
    int nexp, nrel, wait_c, slot;
    nexp = ((ep - sp + 16) % 16) + 1;
    nrel = 1;
    for (int k = 0; k < nexp - 1; k++)
      if (!tb_hold[(sp + k) % 16]) nrel++;
    exp_n = (dv == 0) ? 1 : dv;
    @(negedge clk);
    mon_clr = 1; div = 8'(dv);
    @(negedge clk);
    mon_clr = 0;
    // R10: load beat to the first slot in the same cycle as start
    start = 1; start_ptr = 4'(sp); end_ptr = 4'(ep);
    ld_valid = 1; ld_addr = 4'(sp); ld_tx = newtx;
    ld_cs = tb_cs[sp]; ld_hold = tb_hold[sp]; tb_tx[sp] = newtx;
    @(negedge clk);
    ld_valid = 0;
    chk(done == 0, "R8 done cleared by start", int'(done), 0);
    chk(busy == 1, "R9 busy after start", int'(busy), 1);
    chk(ld_ready == 0, "R1 ready low while busy", int'(ld_ready), 0);
    // R2: a second start while busy, different range, must be ignored
    start_ptr = 4'(sp + 3); end_ptr = 4'(sp + 3);
    @(negedge clk);
    start = 0;
    wait_c = 0;
    while (!done && wait_c < 30000) begin
      @(negedge clk); wait_c++;
    end
    chk(done == 1, "R8 done set", int'(done), 1);
    chk(busy == 0, "R9 busy low at done", int'(busy), 0);
    chk(ld_ready == 1, "R1 ready high when idle", int'(ld_ready), 1);
    repeat (2) @(negedge clk);
    chk(irqs == 1, "R8 single irq", irqs, 1);
    chk(xfer == nexp, "R2 word count", xfer, nexp);
    chk(releases == nrel, "R6 cs releases", releases, nrel);
    chk(lead_bad == 0, "R5 lead half period", lead_bad, 0);
    chk(trail_bad == 0, "R5 trail half period", trail_bad, 0);
    chk(per_bad == 0, "R4 sck period", per_bad, 0);
    chk(gap_bad == 0, "R6 release gap", gap_bad, 0);
    chk(sck == 0, "R3 sck idle low", int'(sck), 0);
    for (int k = 0; k < nexp && k < 32; k++) begin
      slot = (sp + k) % 16;
      chk(cap_mosi[k] == tb_tx[slot], (k == 0) ? "R10 R3 mosi word" : "R3 mosi word",
          int'(cap_mosi[k]), int'(tb_tx[slot]));
      chk(cap_cs[k] == ~tb_cs[slot], "R5 cs pattern", int'(cap_cs[k]), int'(~tb_cs[slot]));
      rd_addr = 4'(slot);
      #1;
      chk(rd_data == resp(k), "R7 rx slot", int'(rd_data), int'(resp(k)));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sck == 0 && mosi == 0, "R3 reset serial lines", int'({sck, mosi}), 0);
    chk(cs_n == 4'hF, "R5 reset cs", int'(cs_n), 15);
    chk(busy == 0 && done == 0 && irq == 0, "R9 reset status", int'({busy, done, irq}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(ld_ready == 1, "R1 ready after reset", int'(ld_ready), 1);
    for (int i = 0; i < 16; i++)
      load(i, 8'(i * 29 + 7), 4'((1 << (i % 4)) | ((i >= 8) ? (1 << ((i + 2) % 4)) : 0)),
           (i % 3) == 1);
    begin
      int dvs [5] = '{0, 1, 2, 3, 5};
      int sps [5] = '{0, 0, 9, 6, 3};
      int eps [5] = '{0, 15, 2, 6, 8};
      for (int d = 0; d < 5; d++)
        for (int r = 0; r < 5; r++)
          run(sps[r], eps[r], dvs[d], 8'(d * 53 + r * 11 + 1));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule